// File: doc/BRIEF.md
# Packet-Holding Round-Robin Transmit Arbiter

This block lets several packet sources, for example a correlation product stream and a beamformed stream, take turns writing into one shared transmit FIFO. The FIFO drains into a network interface more slowly than the sources can fill it. The arbiter scans the request lines in rotating order and grants the first source it finds requesting. The grant then stays with that source until the source's end-of-frame beat has been accepted. After that beat, the arbiter forces a programmable number of dead cycles before it grants anyone, so back-to-back bursts cannot outrun the drain.

A granted source that stops presenting data loses the grant after a fixed window of silent cycles. Each such release sets a sticky error flag and advances a saturating error counter.

Each source offers a valid/ready stream with a last-beat marker, plus a request line. The arbiter raises ready only toward the granted source, and that ready is the downstream ready passed straight through. A source must hold its data and last marker steady while valid is high and ready is low. The muxed output follows the same rule: a beat transfers only in a cycle where `out_valid` and `out_ready` are both high. The arbiter adds no buffering, so the output is combinational from the granted source.

Top module: `pkt_hold_arb`

## Requirements
- R1: After reset, all grant bits are 0, `out_valid` is 0, `wd_err` is 0, `wd_err_count` is 0, and the rotation pointer selects source 0.
- R2: When no grant is held and no gap is running, the arbiter picks the first requesting source, starting at the rotation pointer and counting upward with wrap-around. The grant bit (bit i = source i) goes high one cycle later. The pointer then moves to the source after the one granted, wrapping from the last source to source 0.
- R3: A grant is held, whatever the other request lines do, until the granted source's beat with last = 1 is accepted (valid and ready both high), or until the watchdog releases it.
- R4: While source i holds the grant, `out_valid`, `out_data` and `out_last` equal that source's valid, data and last in the same cycle, and `src_ready[i]` equals `out_ready`. Beats therefore leave in the order the source offered them, and only when `out_ready` is high.
- R5: A source that does not hold the grant sees `src_ready` low. Its valid and data never reach the output, even when it asserts valid without requesting.
- R6: After an accepted last beat, the grant vector stays all-zero for exactly `gap_cfg` + 1 cycles before the next grant, when another request is already waiting. The gap length is taken from `gap_cfg` in the cycle the last beat is accepted, so `gap_cfg` = 0 gives a single idle cycle.
- R7: If the granted source keeps its valid low for WD_CYCLES consecutive granted cycles, the grant is released, so it lasts exactly WD_CYCLES cycles. A release of this kind is followed by the gap of R6. Cycles in which valid is high but `out_ready` is low count as activity and do not advance the watchdog.
- R8: Each watchdog release sets `wd_err` to 1 and increments `wd_err_count` by one, saturating at its maximum. `wd_err` stays 1 until reset, even while later packets complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_SRC | Per-source request to send a packet |
| src_valid | input | N_SRC | Per-source beat valid |
| src_ready | output | N_SRC | Per-source beat ready (high only toward the granted source) |
| src_data | input | N_SRC*DATA_W | Per-source beat data, source i at bits i*DATA_W upward |
| src_last | input | N_SRC | Per-source end-of-frame marker for the current beat |
| src_gnt | output | N_SRC | One-hot grant, bit i = source i |
| out_valid | output | 1 | Muxed output beat valid |
| out_ready | input | 1 | Shared FIFO can accept a beat |
| out_data | output | DATA_W | Muxed output beat data |
| out_last | output | 1 | Muxed end-of-frame marker |
| gap_cfg | input | GAP_W | Dead cycles inserted after each packet |
| wd_err | output | 1 | Sticky watchdog release flag |
| wd_err_count | output | ERR_W | Saturating count of watchdog releases |

## Verification
Results fall due at fixed cycle offsets:
- The grant appears one clock after a request is seen while the arbiter is scanning.
- Output beats follow the granted source's inputs in the same cycle.
- The grant vector drops one clock after the accepted last beat and stays low for `gap_cfg` + 1 sampled cycles.
- A silent source holds the grant for exactly WD_CYCLES sampled cycles, and the error flag and count change one clock after the release.

The bench changes every input on the falling edge and samples outputs a few time units later, so each sample sees the state the next rising edge will act on. A scoreboard queue holds the expected beats in the grant order worked out for each scenario. It pops one entry on every accepted output beat.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;

  typedef enum logic [1:0] {
    ARB_SCAN = 2'd0,
    ARB_HOLD = 2'd1,
    ARB_GAP  = 2'd2
  } arb_state_e;

endpackage

// File: rtl/pkt_arb_rr.sv
module pkt_arb_rr #(
  parameter int N_SRC = 4,
  parameter int IW    = 2
) (
  input  logic [N_SRC-1:0] req,
  input  logic [IW-1:0]    ptr,
  output logic             found,
  output logic [IW-1:0]    pick
);

  // Rotating scan: the first requester at or after ptr, wrapping around.
  always_comb begin : scan_b
    int unsigned idx;
    idx   = 0;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N_SRC; k++) begin
      idx = (int'(ptr) + k) % N_SRC;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/pkt_arb_gap.sv
module pkt_arb_gap #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap_in,
  output logic             expiring
);

  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= gap_in;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expiring = (cnt == GAP_W'(1));

  // R6
  gap_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pkt_arb_wdog.sv
module pkt_arb_wdog #(
  parameter int WD_CYCLES = 16,
  parameter int ERR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             beat,
  output logic             fire,
  output logic             err_flag,
  output logic [ERR_W-1:0] err_count
);

  localparam int CW = $clog2(WD_CYCLES + 1);

  logic [CW-1:0] idle_cnt;

  assign fire = active && !beat && (idle_cnt == CW'(WD_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (!active || beat || fire) begin
      idle_cnt <= '0;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_count <= '0;
    end else if (fire) begin
      err_flag <= 1'b1;
      if (err_count != '1) err_count <= err_count + 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R8
  err_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (err_flag && ((err_count == $past(err_count) + 1'b1) || ($past(err_count) == '1))));

  // R7
  beat_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> !fire);

endmodule

// File: rtl/pkt_hold_arb.sv
module pkt_hold_arb
  import pkt_arb_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int DATA_W    = 16,
  parameter int GAP_W     = 4,
  parameter int WD_CYCLES = 16,
  parameter int ERR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_req,
  input  logic [N_SRC-1:0]        src_valid,
  output logic [N_SRC-1:0]        src_ready,
  input  logic [N_SRC*DATA_W-1:0] src_data,
  input  logic [N_SRC-1:0]        src_last,
  output logic [N_SRC-1:0]        src_gnt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_last,
  input  logic [GAP_W-1:0]        gap_cfg,
  output logic                    wd_err,
  output logic [ERR_W-1:0]        wd_err_count
);

  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  arb_state_e    state;
  logic [IW-1:0] owner;
  logic [IW-1:0] ptr;
  logic          found;
  logic [IW-1:0] pick;
  logic          holding;
  logic          sel_valid;
  logic          eof_beat;
  logic          wd_fire;
  logic          release_now;
  logic          gap_expiring;

  pkt_arb_rr #(.N_SRC(N_SRC), .IW(IW)) u_rr (
    .req   (src_req),
    .ptr   (ptr),
    .found (found),
    .pick  (pick)
  );

  assign holding     = (state == ARB_HOLD);
  assign sel_valid   = holding && src_valid[owner];
  assign eof_beat    = sel_valid && out_ready && src_last[owner];
  assign release_now = holding && (eof_beat || wd_fire);

  pkt_arb_wdog #(.WD_CYCLES(WD_CYCLES), .ERR_W(ERR_W)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (holding),
    .beat      (sel_valid),
    .fire      (wd_fire),
    .err_flag  (wd_err),
    .err_count (wd_err_count)
  );

  pkt_arb_gap #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (release_now),
    .gap_in   (gap_cfg),
    .expiring (gap_expiring)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ARB_SCAN;
      owner <= '0;
      ptr   <= '0;
    end else begin
      case (state)
        ARB_SCAN: begin
          if (found) begin
            state <= ARB_HOLD;
            owner <= pick;
            ptr   <= (pick == IW'(N_SRC - 1)) ? '0 : pick + 1'b1;
          end
        end
        ARB_HOLD: begin
          if (release_now) state <= (gap_cfg == '0) ? ARB_SCAN : ARB_GAP;
        end
        ARB_GAP: begin
          if (gap_expiring) state <= ARB_SCAN;
        end
        default: state <= ARB_SCAN;
      endcase
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_port
    assign src_gnt[g]   = holding && (owner == IW'(g));
    assign src_ready[g] = src_gnt[g] && out_ready;
  end

  assign out_valid = sel_valid;
  assign out_last  = holding && src_last[owner];
  assign out_data  = src_data[int'(owner)*DATA_W +: DATA_W];

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_gnt));

  // R2
  gnt_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_gnt && !$past(|src_gnt)) |-> |($past(src_req) & src_gnt));

  // R3
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_gnt && !(out_valid && out_ready && out_last) && !wd_fire) |=> (src_gnt == $past(src_gnt)));

  // R5
  out_from_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(src_gnt & src_valid) == 1));

  // R6
  eof_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (src_gnt == '0));

endmodule

// File: tb/sim_pkt_hold_arb.sv
module sim_pkt_hold_arb;

  localparam int N  = 4;
  localparam int DW = 16;
  localparam int GW = 4;
  localparam int WD = 16;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic [N-1:0]  src_valid = '0;
  logic [N-1:0]  src_ready;
  logic [N*DW-1:0] src_data = '0;
  logic [N-1:0]  src_last = '0;
  logic [N-1:0]  src_gnt;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          out_last;
  logic [GW-1:0] gap_cfg = 4'd2;
  logic          wd_err;
  logic [EW-1:0] wd_err_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW:0] srcq [N][$];
  logic [DW:0] expq [$];
  int          pkt_id [N];
  bit [N-1:0]  hs = '0;
  bit [N-1:0]  stall = '0;
  bit [N-1:0]  rogue = '0;
  bit          gap_counting = 0;
  int          gap_run = 0;
  int          last_gap = -1;

  always #10 clk = ~clk;

  pkt_hold_arb #(.N_SRC(N), .DATA_W(DW), .GAP_W(GW), .WD_CYCLES(WD), .ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
    .src_gnt(src_gnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .gap_cfg(gap_cfg),
    .wd_err(wd_err), .wd_err_count(wd_err_count)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver task: queues a packet at its source and its expected beats on the scoreboard.
  task automatic send_pkt(input int s, input int len);
    for (int w = 0; w < len; w++) begin
      logic [DW:0] item;
      item = {(w == len - 1), 4'(s), 4'(pkt_id[s]), 8'(w)};
      srcq[s].push_back(item);
      expq.push_back(item);
    end
    pkt_id[s]++;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic set_ready(input bit v);
    @(negedge clk);
    out_ready = v;
    #3;
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      bit busy;
      busy = (expq.size() != 0);
      for (int s = 0; s < N; s++) if (srcq[s].size() != 0) busy = 1;
      if (!busy) break;
      tick(1);
    end
    tick(12);
  endtask

  task automatic stall_run(input int s, output int run);
    run = 0;
    stall[s] = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (src_gnt[s]) break;
      tick(1);
    end
    for (int k = 0; k < 200; k++) begin
      if (!src_gnt[s]) break;
      run++;
      tick(1);
    end
    stall[s] = 1'b0;
    tick(12);
  endtask

  // Source models: change at the falling edge, then note which beats the next rising edge accepts.
  always @(negedge clk) begin
    for (int s = 0; s < N; s++)
      if (hs[s] && srcq[s].size() != 0) void'(srcq[s].pop_front());
    for (int s = 0; s < N; s++) begin
      if (srcq[s].size() != 0) begin
        src_req[s]            = 1'b1;
        src_valid[s]          = 1'b1;
        src_data[s*DW +: DW]  = srcq[s][0][DW-1:0];
        src_last[s]           = srcq[s][0][DW];
      end else begin
        src_req[s]            = stall[s];
        src_valid[s]          = rogue[s];
        src_data[s*DW +: DW]  = rogue[s] ? 16'hEEEE : 16'h0000;
        src_last[s]           = 1'b0;
      end
    end
    #1;
    for (int s = 0; s < N; s++) hs[s] = src_valid[s] && src_ready[s];
  end

  // Monitor: pops the scoreboard on each accepted output beat and measures the gaps between grants.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5 unexpected output beat", longint'({out_last, out_data}), -1);
        end else begin
          logic [DW:0] e;
          e = expq.pop_front();
          check({out_last, out_data} === e, "R4 output beat", longint'({out_last, out_data}), longint'(e));
        end
      end
      if (gap_counting) begin
        if (src_gnt == '0) gap_run++;
        else begin
          last_gap = gap_run;
          gap_counting = 0;
        end
      end
      if (out_valid && out_ready && out_last) begin
        gap_counting = 1;
        gap_run = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int run;
    for (int s = 0; s < N; s++) pkt_id[s] = 0;
    tick(5);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R1 reset state
    check(src_gnt == '0, "R1 grant after reset", src_gnt, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(wd_err == 1'b0, "R1 wd_err after reset", wd_err, 0);
    check(wd_err_count == '0, "R1 wd_err_count after reset", wd_err_count, 0);

    // R2 all four request at once with pointer at 0: order 0,1,2,3
    send_pkt(0, 3); send_pkt(1, 3); send_pkt(2, 3); send_pkt(3, 3);
    tick(3);
    // R3 source 0 keeps the grant while the others request
    check(src_gnt == 4'b0001, "R3 grant held by source 0", src_gnt, 1);
    check(src_req == 4'b1111, "R3 others still requesting", src_req, 15);
    drain();
    check(expq.size() == 0, "R2 all beats of round 0..3 seen", expq.size(), 0);
    // R6 gap of gap_cfg+1 = 3
    check(last_gap == 3, "R6 gap with gap_cfg=2", last_gap, 3);

    // R2 pointer at 0: sources 2 and 1 request, expect 1 then 2
    send_pkt(1, 2); send_pkt(2, 2);
    drain();
    check(expq.size() == 0, "R2 order 1 then 2", expq.size(), 0);

    // R2 pointer at 3: sources 0 and 3 request, expect 3 then 0 (wrap)
    send_pkt(3, 2); send_pkt(0, 2);
    drain();
    check(expq.size() == 0, "R2 wrap order 3 then 0", expq.size(), 0);

    // R6 gap_cfg = 0 gives one idle cycle (pointer at 1: 1 then 2)
    gap_cfg = 4'd0;
    send_pkt(1, 2); send_pkt(2, 2);
    drain();
    check(last_gap == 1, "R6 gap with gap_cfg=0", last_gap, 1);

    // R6 gap_cfg = 5 (pointer at 3: 3 then 0)
    gap_cfg = 4'd5;
    send_pkt(3, 3); send_pkt(0, 3);
    drain();
    check(last_gap == 6, "R6 gap with gap_cfg=5", last_gap, 6);
    gap_cfg = 4'd2;

    // R5 source 2 asserts valid without a request while source 0 sends
    rogue[2] = 1'b1;
    send_pkt(0, 6);
    tick(3);
    check(src_gnt == 4'b0001, "R5 grant at source 0", src_gnt, 1);
    check(src_ready[2] == 1'b0, "R5 ungranted source sees no ready", src_ready[2], 0);
    drain();
    check(src_gnt[2] == 1'b0, "R5 rogue source never granted", src_gnt[2], 0);
    rogue[2] = 1'b0;
    tick(2);

    // R4 and R7 back-pressure: valid held with ready low is activity
    set_ready(1'b0);
    send_pkt(3, 4);
    for (int k = 0; k < 50; k++) begin
      if (src_gnt[3]) break;
      tick(1);
    end
    tick(2 * WD);
    check(src_gnt[3] == 1'b1, "R7 grant kept under back-pressure", src_gnt[3], 1);
    check(wd_err_count == '0, "R7 no watchdog under back-pressure", wd_err_count, 0);
    check(out_valid == 1'b1, "R4 out_valid follows source", out_valid, 1);
    for (int k = 0; k < 8; k++) set_ready(k[0]);
    set_ready(1'b1);
    drain();
    check(expq.size() == 0, "R4 beats under back-pressure", expq.size(), 0);

    // R7 silent source loses grant after WD cycles
    stall_run(1, run);
    check(run == WD, "R7 stalled grant length", run, WD);
    check(wd_err == 1'b1, "R8 flag after first release", wd_err, 1);
    check(wd_err_count == 8'd1, "R8 count after first release", wd_err_count, 1);

    // R8 flag stays set through a normal packet
    send_pkt(2, 2);
    drain();
    check(wd_err == 1'b1, "R8 flag sticky", wd_err, 1);
    check(expq.size() == 0, "R3 packet after release", expq.size(), 0);

    stall_run(0, run);
    check(run == WD, "R7 second stalled grant length", run, WD);
    check(wd_err_count == 8'd2, "R8 count after second release", wd_err_count, 2);
    check(src_gnt == '0, "R7 no grant once idle", src_gnt, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule